// File: doc/BRIEF.md
# Bit-Selection Decision Tree Packet Classifier

This block classifies packet headers by walking a decision tree held in on-chip node storage. A header is the 104-bit 5-tuple: source address, destination address, source port, destination port and protocol. Every internal node carries its own mask that can pick any single bits of the whole header. The picked bits are collected at once and packed into a dense index, and that index is added to the node's child base to reach the next node. When the walk reaches a leaf, the leaf names a small group of rules. Those rules are compared with the full header, and the lowest-numbered rule that matches gives the result.

The walk is pipelined with one tree level per stage, so a new header can enter on every clock. Results leave in order through a valid/ready pair that can stall the whole pipeline. Nodes and rules are loaded through two plain write ports. Building the tree and choosing which bits to cut are done elsewhere.

Header bit layout: bits 103:72 source address, 71:40 destination address, 39:24 source port, 23:8 destination port, 7:0 protocol.

Top module: `bsw_tree_walker`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, every node word reads as zero (an internal node with an empty mask and base 0) and every rule slot is invalid. Any header sent before loading therefore returns no-match.
- R2: A node write at `wr_node_addr` stores a leaf flag, a 104-bit cut mask and a base of `NODE_AW` bits. Node 0 is the root of every walk.
- R3: At an internal node the child address is base plus the gathered index, truncated to `NODE_AW` bits. The lowest set mask bit becomes index bit 0, the next set bit becomes index bit 1, and so on, up to `SEL_MAX` (8) bits.
- R4: At a leaf node the low `LEAF_AW` bits of the base select a rule group, and later stages keep that group unchanged. Rule slot s of group g is written at rule address {g, s}, so the address is g*RPL+s.
- R5: A rule matches when its valid bit is set and the header equals its value on every bit where its care mask is 1. When several rules match, the lowest slot wins and `out_hit`=1 with that rule's ID.
- R6: When no rule of the group matches, including a group with no valid rules, `out_hit`=0 and `out_id` is all ones.
- R7: When no leaf is reached within `DEPTH` node reads, the result is no-match as in R6.
- R8: One header is accepted per clock. Without a stall, the result appears `DEPTH` clock edges after the edge that accepts the header, and results come out in the order the headers went in.
- R9: While `out_valid`=1 and `out_ready`=0, the output holds stable, `in_ready` is 0, and no header is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header accepted at this edge if valid |
| in_hdr | input | 104 | 5-tuple header |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | A rule matched |
| out_id | output | ID_W | Matching rule ID, all ones on no-match |
| wr_node_en | input | 1 | Write one node word |
| wr_node_addr | input | NODE_AW | Node address |
| wr_node_leaf | input | 1 | Leaf flag |
| wr_node_mask | input | 104 | Cut mask |
| wr_node_base | input | NODE_AW | Child base, or rule group for a leaf |
| wr_rule_en | input | 1 | Write one rule slot |
| wr_rule_addr | input | LEAF_AW+log2(RPL) | {group, slot} |
| wr_rule_valid | input | 1 | Slot holds a rule |
| wr_rule_value | input | 104 | Header value to compare |
| wr_rule_care | input | 104 | Bits that take part in the compare |
| wr_rule_id | input | ID_W | Rule ID returned on a hit |

## Verification
A result is due `DEPTH` edges after the edge that accepts its header, and there are no stalls in the streaming phases. The bench records the cycle count at the falling edge where it sees a header accepted, and it expects the matching result at the falling edge exactly `DEPTH`+1 counts later, sampling only on falling edges. During the stall phase the bench does not check timing. It checks that the held output stays the same across several cycles and that in-order delivery resumes once `out_ready` returns.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
   localparam int HDR_W   = 104;
   localparam int SA_LSB  = 72;
   localparam int DA_LSB  = 40;
   localparam int SP_LSB  = 24;
   localparam int DP_LSB  = 8;
   localparam int PR_LSB  = 0;
endpackage

// File: rtl/bsw_gather.sv
// Parallel bit gather: set mask bits, lowest first, are packed into idx.
module bsw_gather
   import bsw_pkg::*;
#(
   parameter int SEL = 8
) (
   input  logic [HDR_W-1:0] hdr,
   input  logic [HDR_W-1:0] mask,
   output logic [SEL-1:0]   idx
);
   always_comb begin
      int pos;
      idx = '0;
      pos = 0;
      for (int i = 0; i < HDR_W; i++) begin
         if (mask[i]) begin
            if (pos < SEL) idx[pos] = hdr[i];
            pos = pos + 1;
         end
      end
   end
endmodule

// File: rtl/bsw_level.sv
// One tree level: reads a node word, computes the next address, registers it.
module bsw_level
   import bsw_pkg::*;
#(
   parameter int NAW = 8,
   parameter int SEL = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             in_vld,
   input  logic [HDR_W-1:0] in_hdr,
   input  logic [NAW-1:0]   in_addr,
   input  logic             in_leaf,
   input  logic             nd_leaf,
   input  logic [HDR_W-1:0] nd_mask,
   input  logic [NAW-1:0]   nd_base,
   output logic             out_vld,
   output logic [HDR_W-1:0] out_hdr,
   output logic [NAW-1:0]   out_addr,
   output logic             out_leaf
);
   localparam int SUM_W = (NAW > SEL) ? NAW : SEL;

   logic [SEL-1:0]   idx;
   logic [SUM_W-1:0] child_sum;
   logic [NAW-1:0]   nxt_addr;
   logic             nxt_leaf;

   bsw_gather #(.SEL(SEL)) u_gather (
      .hdr  (in_hdr),
      .mask (nd_mask),
      .idx  (idx)
   );

   assign child_sum = SUM_W'(nd_base) + SUM_W'(idx);

   always_comb begin
      if (in_leaf) begin
         nxt_addr = in_addr;
         nxt_leaf = 1'b1;
      end else if (nd_leaf) begin
         nxt_addr = nd_base;
         nxt_leaf = 1'b1;
      end else begin
         nxt_addr = child_sum[NAW-1:0];
         nxt_leaf = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_hdr  <= '0;
         out_addr <= '0;
         out_leaf <= 1'b0;
      end else if (adv) begin
         out_vld  <= in_vld;
         out_hdr  <= in_hdr;
         out_addr <= nxt_addr;
         out_leaf <= nxt_leaf;
      end
   end

   // R4: a walk that already reached a leaf keeps its rule group
   assert_leaf_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adv && in_vld && in_leaf |=> out_leaf && (out_addr == $past(in_addr)));
   // R8: each stage moves valid forward on every advance
   assert_flow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (out_vld == $past(in_vld)));
endmodule

// File: rtl/bsw_leaf_match.sv
// Priority compare of one rule group against the header, result registered.
module bsw_leaf_match
   import bsw_pkg::*;
#(
   parameter int RPL  = 4,
   parameter int ID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             in_vld,
   input  logic             in_leaf,
   input  logic [HDR_W-1:0] in_hdr,
   input  logic             r_vld  [RPL],
   input  logic [HDR_W-1:0] r_val  [RPL],
   input  logic [HDR_W-1:0] r_care [RPL],
   input  logic [ID_W-1:0]  r_id   [RPL],
   output logic             out_valid,
   output logic             out_hit,
   output logic [ID_W-1:0]  out_id
);
   logic [RPL-1:0] slot_hit;
   logic           any_hit;
   logic [ID_W-1:0] win_id;

   for (genvar j = 0; j < RPL; j++) begin : g_slot
      assign slot_hit[j] = in_leaf && r_vld[j] &&
                           (((in_hdr ^ r_val[j]) & r_care[j]) == '0);
   end

   always_comb begin
      any_hit = 1'b0;
      win_id  = '1;
      for (int j = RPL - 1; j >= 0; j--) begin
         if (slot_hit[j]) begin
            any_hit = 1'b1;
            win_id  = r_id[j];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hit   <= 1'b0;
         out_id    <= '1;
      end else if (adv) begin
         out_valid <= in_vld;
         out_hit   <= any_hit;
         out_id    <= win_id;
      end
   end

   // R7: a walk that ended without a leaf yields no-match
   assert_no_leaf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      adv && in_vld && !in_leaf |=> out_valid && !out_hit && (&out_id));
   // R6: a miss always carries the all-ones ID
   assert_miss_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_hit |-> (&out_id));
endmodule

// File: rtl/bsw_tree_walker.sv
module bsw_tree_walker
   import bsw_pkg::*;
#(
   parameter  int DEPTH   = 4,
   parameter  int NODE_AW = 8,
   parameter  int SEL_MAX = 8,
   parameter  int LEAF_AW = 4,
   parameter  int RPL     = 4,
   parameter  int ID_W    = 8,
   localparam int SLOT_W  = $clog2(RPL),
   localparam int RULE_AW = LEAF_AW + SLOT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [HDR_W-1:0]   in_hdr,
   output logic               out_valid,
   input  logic               out_ready,
   output logic               out_hit,
   output logic [ID_W-1:0]    out_id,
   input  logic               wr_node_en,
   input  logic [NODE_AW-1:0] wr_node_addr,
   input  logic               wr_node_leaf,
   input  logic [HDR_W-1:0]   wr_node_mask,
   input  logic [NODE_AW-1:0] wr_node_base,
   input  logic               wr_rule_en,
   input  logic [RULE_AW-1:0] wr_rule_addr,
   input  logic               wr_rule_valid,
   input  logic [HDR_W-1:0]   wr_rule_value,
   input  logic [HDR_W-1:0]   wr_rule_care,
   input  logic [ID_W-1:0]    wr_rule_id
);
   localparam int NODES = 1 << NODE_AW;
   localparam int RULES = 1 << RULE_AW;

   if (DEPTH < 1)              begin : g_chk_depth $error("DEPTH must be at least 1"); end
   if (SEL_MAX < 1 || SEL_MAX > 16) begin : g_chk_sel $error("SEL_MAX out of range"); end
   if (RPL < 2 || (1 << SLOT_W) != RPL) begin : g_chk_rpl $error("RPL must be a power of two >= 2"); end
   if (LEAF_AW > NODE_AW)      begin : g_chk_leaf $error("LEAF_AW exceeds NODE_AW"); end

   // node storage
   logic               nd_leaf_q [NODES];
   logic [HDR_W-1:0]   nd_mask_q [NODES];
   logic [NODE_AW-1:0] nd_base_q [NODES];
   // rule storage
   logic               ru_vld_q  [RULES];
   logic [HDR_W-1:0]   ru_val_q  [RULES];
   logic [HDR_W-1:0]   ru_care_q [RULES];
   logic [ID_W-1:0]    ru_id_q   [RULES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < NODES; n++) begin
            nd_leaf_q[n] <= 1'b0;
            nd_mask_q[n] <= '0;
            nd_base_q[n] <= '0;
         end
      end else if (wr_node_en) begin
         nd_leaf_q[wr_node_addr] <= wr_node_leaf;
         nd_mask_q[wr_node_addr] <= wr_node_mask;
         nd_base_q[wr_node_addr] <= wr_node_base;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < RULES; r++) begin
            ru_vld_q[r]  <= 1'b0;
            ru_val_q[r]  <= '0;
            ru_care_q[r] <= '0;
            ru_id_q[r]   <= '0;
         end
      end else if (wr_rule_en) begin
         ru_vld_q[wr_rule_addr]  <= wr_rule_valid;
         ru_val_q[wr_rule_addr]  <= wr_rule_value;
         ru_care_q[wr_rule_addr] <= wr_rule_care;
         ru_id_q[wr_rule_addr]   <= wr_rule_id;
      end
   end

   // the whole pipeline advances unless a held result blocks it
   logic adv;
   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;

   logic               st_vld  [DEPTH+1];
   logic [HDR_W-1:0]   st_hdr  [DEPTH+1];
   logic [NODE_AW-1:0] st_addr [DEPTH+1];
   logic               st_leaf [DEPTH+1];

   assign st_vld[0]  = in_valid;
   assign st_hdr[0]  = in_hdr;
   assign st_addr[0] = '0;
   assign st_leaf[0] = 1'b0;

   for (genvar lv = 0; lv < DEPTH; lv++) begin : g_level
      bsw_level #(.NAW(NODE_AW), .SEL(SEL_MAX)) u_level (
         .clk      (clk),
         .rst_n    (rst_n),
         .adv      (adv),
         .in_vld   (st_vld[lv]),
         .in_hdr   (st_hdr[lv]),
         .in_addr  (st_addr[lv]),
         .in_leaf  (st_leaf[lv]),
         .nd_leaf  (nd_leaf_q[st_addr[lv]]),
         .nd_mask  (nd_mask_q[st_addr[lv]]),
         .nd_base  (nd_base_q[st_addr[lv]]),
         .out_vld  (st_vld[lv+1]),
         .out_hdr  (st_hdr[lv+1]),
         .out_addr (st_addr[lv+1]),
         .out_leaf (st_leaf[lv+1])
      );
   end

   logic [LEAF_AW-1:0] grp;
   assign grp = st_addr[DEPTH][LEAF_AW-1:0];

   logic             gr_vld  [RPL];
   logic [HDR_W-1:0] gr_val  [RPL];
   logic [HDR_W-1:0] gr_care [RPL];
   logic [ID_W-1:0]  gr_id   [RPL];

   for (genvar j = 0; j < RPL; j++) begin : g_grp
      localparam logic [SLOT_W-1:0] SLOT = SLOT_W'(j);
      assign gr_vld[j]  = ru_vld_q [{grp, SLOT}];
      assign gr_val[j]  = ru_val_q [{grp, SLOT}];
      assign gr_care[j] = ru_care_q[{grp, SLOT}];
      assign gr_id[j]   = ru_id_q  [{grp, SLOT}];
   end

   bsw_leaf_match #(.RPL(RPL), .ID_W(ID_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .in_vld    (st_vld[DEPTH]),
      .in_leaf   (st_leaf[DEPTH]),
      .in_hdr    (st_hdr[DEPTH]),
      .r_vld     (gr_vld),
      .r_val     (gr_val),
      .r_care    (gr_care),
      .r_id      (gr_id),
      .out_valid (out_valid),
      .out_hit   (out_hit),
      .out_id    (out_id)
   );

   // R9: a stalled result stays put
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_hit));
   // R3: a node may cut at most SEL_MAX bits
   assert_mask_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_node_en |-> ($countones(wr_node_mask) <= SEL_MAX));
endmodule

// File: tb/sim_bsw_tree_walker.sv
module sim_bsw_tree_walker;
   localparam int DEPTH = 4;
   localparam int NAW   = 8;
   localparam int LAW   = 4;
   localparam int RPL   = 4;
   localparam int IDW   = 8;
   localparam int RAW   = LAW + 2;
   localparam int NV    = 11;

   localparam logic [103:0] C_PR = 104'hFF;
   localparam logic [103:0] C_DP = 104'hFFFF << 8;
   localparam logic [103:0] C_SP = 104'hFFFF << 24;
   localparam logic [103:0] C_SA = 104'hFF << 96;
   localparam logic [103:0] H_EX = {32'h0B000000, 32'h01020304, 16'd5555, 16'd81, 8'd6};

   // stimulus table: header, expected id, expected hit
   localparam logic [103:0] T_HDR [NV] = '{
      {32'h0A010101, 32'hC0A80002, 16'd1000, 16'd80, 8'd6},  // 0 idx0 grp1 slot0
      {32'h0A010101, 32'hC0A80002, 16'd1000, 16'd80, 8'd4},  // 1 grp1 catch-all
      {32'h0A000002, 32'hC0A80002, 16'd1000, 16'd80, 8'd17}, // 2 node17->40 grp2 priority
      {32'h0A000002, 32'hC0A80002, 16'd1234, 16'd82, 8'd17}, // 3 grp2 slot3
      {32'h0A000002, 32'hC0A80003, 16'd1234, 16'd80, 8'd17}, // 4 node41 grp3 empty
      {32'h0A000003, 32'hC0A80002, 16'd1000, 16'd80, 8'd17}, // 5 node42 grp2
      {32'h8A000000, 32'hC0A80002, 16'd1000, 16'd80, 8'd6},  // 6 no leaf in depth
      {32'h0A123456, 32'h01020304, 16'd1000, 16'd81, 8'd6},  // 7 node18 grp4 slot0
      {32'h0B000000, 32'h01020304, 16'd5555, 16'd81, 8'd6},  // 8 grp4 exact slot3
      {32'h0B000000, 32'h01020304, 16'd5555, 16'd81, 8'd2},  // 9 one bit off
      {32'h0A000000, 32'h01020304, 16'd1000, 16'd81, 8'd7}   // 10 node19 grp4
   };
   localparam logic [7:0] T_ID  [NV] = '{8'd10, 8'd11, 8'd21, 8'd23, 8'hFF, 8'd21,
                                        8'hFF, 8'd40, 8'd43, 8'hFF, 8'd40};
   localparam bit         T_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
                                        1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [103:0]     in_hdr = '0;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic             out_hit;
   logic [IDW-1:0]   out_id;
   logic             wr_node_en = 1'b0;
   logic [NAW-1:0]   wr_node_addr = '0;
   logic             wr_node_leaf = 1'b0;
   logic [103:0]     wr_node_mask = '0;
   logic [NAW-1:0]   wr_node_base = '0;
   logic             wr_rule_en = 1'b0;
   logic [RAW-1:0]   wr_rule_addr = '0;
   logic             wr_rule_valid = 1'b0;
   logic [103:0]     wr_rule_value = '0;
   logic [103:0]     wr_rule_care = '0;
   logic [IDW-1:0]   wr_rule_id = '0;

   always #4 clk = ~clk;

   bsw_tree_walker #(.DEPTH(DEPTH), .NODE_AW(NAW), .SEL_MAX(8), .LEAF_AW(LAW),
                     .RPL(RPL), .ID_W(IDW)) u0 (
      .clk, .rst_n, .in_valid, .in_ready, .in_hdr, .out_valid, .out_ready,
      .out_hit, .out_id, .wr_node_en, .wr_node_addr, .wr_node_leaf,
      .wr_node_mask, .wr_node_base, .wr_rule_en, .wr_rule_addr, .wr_rule_valid,
      .wr_rule_value, .wr_rule_care, .wr_rule_id
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // expected-result queue
   logic [IDW-1:0] e_id  [64];
   bit             e_hit [64];
   int             e_cyc [64];
   bit             e_lat [64];
   string          e_req [64];
   int             wr_i = 0;
   int             rd_i = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(int i);
      case (i)
         0, 1:    return "R3 R5";
         2:       return "R5 priority";
         4, 9:    return "R6";
         6:       return "R7";
         default: return "R4 R5";
      endcase
   endfunction

   // monitor: compares every delivered result in order
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (rd_i >= wr_i) begin
            chk(1'b0, "R9", "unexpected extra result", out_id, 0);
         end else begin
            chk(out_hit == e_hit[rd_i] && out_id == e_id[rd_i], e_req[rd_i],
                "hit/id", {out_hit, out_id}, {e_hit[rd_i], e_id[rd_i]});
            if (e_lat[rd_i])
               chk(cyc == e_cyc[rd_i] + DEPTH + 1, "R8", "result latency",
                   cyc - e_cyc[rd_i], DEPTH + 1);
            rd_i++;
         end
      end
   end

   task automatic send(logic [103:0] h, logic [IDW-1:0] id, bit hit, string req, bit lat);
      @(negedge clk);
      in_valid = 1'b1;
      in_hdr   = h;
      while (!in_ready) @(negedge clk);
      e_id[wr_i]  = id;
      e_hit[wr_i] = hit;
      e_cyc[wr_i] = cyc;
      e_lat[wr_i] = lat;
      e_req[wr_i] = req;
      wr_i++;
   endtask

   task automatic idle_in();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      for (int k = 0; k < 40 && rd_i < wr_i; k++) @(negedge clk);
   endtask

   task automatic wnode(int a, bit leaf, logic [103:0] m, int b);
      @(negedge clk);
      wr_node_en   = 1'b1;
      wr_node_addr = NAW'(a);
      wr_node_leaf = leaf;
      wr_node_mask = m;
      wr_node_base = NAW'(b);
      @(negedge clk);
      wr_node_en   = 1'b0;
   endtask

   task automatic wrule(int grp, int slot, logic [103:0] v, logic [103:0] c, int id);
      @(negedge clk);
      wr_rule_en    = 1'b1;
      wr_rule_addr  = RAW'(grp * RPL + slot);
      wr_rule_valid = 1'b1;
      wr_rule_value = v;
      wr_rule_care  = c;
      wr_rule_id    = IDW'(id);
      @(negedge clk);
      wr_rule_en    = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "R8", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
      // R1: empty tree gives no-match
      send(T_HDR[0], 8'hFF, 1'b0, "R1", 1'b1);
      idle_in();
      drain();

      // tree load (R2): root cuts on proto bit0, dst-port bit0, src-addr bit31
      wnode(0, 1'b0, (104'h1 << 0) | (104'h1 << 8) | (104'h1 << 103), 16);
      wnode(16, 1'b1, '0, 1);
      wnode(17, 1'b0, (104'h1 << 40) | (104'h1 << 72), 40);
      wnode(18, 1'b1, '0, 4);
      wnode(19, 1'b1, '0, 4);
      wnode(20, 1'b0, '0, 60);
      wnode(21, 1'b1, '0, 4);
      wnode(22, 1'b1, '0, 4);
      wnode(23, 1'b1, '0, 4);
      wnode(40, 1'b1, '0, 2);
      wnode(41, 1'b1, '0, 3);
      wnode(42, 1'b1, '0, 2);
      wnode(43, 1'b1, '0, 2);
      wnode(60, 1'b0, '0, 61);
      wnode(61, 1'b0, '0, 62);
      wrule(1, 0, 104'd6, C_PR, 10);
      wrule(1, 1, '0, '0, 11);
      wrule(2, 1, 104'd80 << 8, C_DP, 21);
      wrule(2, 2, (104'd80 << 8) | 104'd17, C_DP | C_PR, 22);
      wrule(2, 3, 104'd1234 << 24, C_SP, 23);
      wrule(4, 0, 104'h0A << 96, C_SA, 40);
      wrule(4, 3, H_EX, '1, 43);

      // table walk, back to back (R8 throughput and order)
      for (int i = 0; i < NV; i++) send(T_HDR[i], T_ID[i], T_HIT[i], tag_of(i), 1'b1);
      idle_in();
      drain();
      chk(rd_i == wr_i, "R8", "all streamed results delivered", rd_i, wr_i);

      // R9: backpressure
      @(negedge clk);
      out_ready = 1'b0;
      send(T_HDR[0], T_ID[0], T_HIT[0], "R9", 1'b0);
      send(T_HDR[7], T_ID[7], T_HIT[7], "R9", 1'b0);
      idle_in();
      repeat (8) @(negedge clk);
      chk(out_valid == 1'b1, "R9", "out_valid held", out_valid, 1);
      chk(out_id == 8'd10 && out_hit, "R9", "held result", out_id, 10);
      chk(in_ready == 1'b0, "R9", "in_ready low while held", in_ready, 0);
      repeat (3) @(negedge clk);
      chk(out_id == 8'd10 && out_valid, "R9", "result stable over stall", out_id, 10);
      out_ready = 1'b1;
      drain();
      repeat (4) @(negedge clk);
      chk(rd_i == wr_i, "R9", "stalled results delivered once", rd_i, wr_i);
      chk(out_valid == 1'b0, "R9", "no duplicate after drain", out_valid, 0);
      finish_run();
   end
endmodule